// File: doc/BRIEF.md
# Asymmetric Decoder Slot Allocator

This block sits between an instruction queue and the rename stage. Each cycle it sees up to five records at the head of the queue, each record holding a micro-op count, a compare flag, a conditional-jump flag and a long-mode bit. It hands the records, in program order, to four decode slots. Slot 0 is the complex slot and takes an instruction of one to four micro-ops. Slots 1 to 3 are simple slots and take single-micro-op instructions only. It also reports how many records it consumed, so the queue can pop them in the same cycle.

Two special paths exist. The first handles an adjacent compare and conditional jump, each of one micro-op. The pair is merged into a single micro-op in one slot, so one cycle can consume as many as five records. The second handles an instruction of more than four micro-ops. It goes to an internal microcode sequencer, which streams its micro-ops at up to four per clock. Slot allocation waits while the sequencer runs.

Top module: `dec_slot_alloc`

## Requirements
- R1: Slot 0 accepts the record at lane 0 when that record carries 1 to 4 micro-ops. The slot reports that record's count in `slot_uops`.
- R2: Slots 1 to 3 accept only single-micro-op records. When a record of more than one micro-op is reached in any slot after slot 0, the group ends there. That record is left in the queue and goes to slot 0 in a later cycle.
- R3: Records are placed in program order. Slot s is filled only if every lower slot is filled. `slot_idx` gives the queue lane (0 = head) of the record, or of the first record of a pair, in each filled slot. Unfilled slots report index 0, count 0 and no fusion.
- R4: The total number of micro-ops sent to rename in one cycle never exceeds 4. A record that would push the total over 4 ends the group. For example, the counts 4,1,1,1 take two cycles.
- R5: When the lane-0 record carries more than 4 micro-ops and the sequencer is idle, that cycle fills no slot, sends no micro-ops, sets `consumed` to 1 and pulses `seq_start`. From the next cycle on, `seq_busy` is 1.
- R6: While `seq_busy` is 1, the sequencer sends min(4, remaining) micro-ops per cycle on `rn_uops`. It raises `seq_done` in the cycle that sends the last of them and is idle the cycle after. No slot is filled and `consumed` is 0 while it is busy.
- R7: A record with the compare flag that is directly followed by a record with the jump flag, both carrying one micro-op, fills one slot. That slot has `slot_fused` set, counts 1 micro-op and consumes 2 records. Up to 5 records can be consumed in one cycle.
- R8: At most one fused pair is formed per cycle. A later compare-jump pair in the same group is placed as two single records.
- R9: No pair is fused when the compare record's long-mode bit is 1. Both records are then placed as single records.
- R10: After reset, no slot is filled, `consumed`, `rn_uops` and all sequencer outputs are 0. Lanes at or after the first record with its valid bit clear are never placed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iq_vld | input | 5 | Per-lane record valid bits; lane 0 is the oldest record |
| iq_uops | input | 20 | Per-lane micro-op count, 4 bits per lane |
| iq_cmp | input | 5 | Per-lane compare flag |
| iq_jcc | input | 5 | Per-lane conditional-jump flag |
| iq_long | input | 5 | Per-lane long-mode bit |
| slot_vld | output | 4 | Slot filled this cycle |
| slot_idx | output | 12 | Per-slot queue lane, 3 bits per slot |
| slot_uops | output | 16 | Per-slot micro-op count, 4 bits per slot |
| slot_fused | output | 4 | Slot holds a fused compare-jump pair |
| consumed | output | 3 | Records the queue must pop this cycle |
| rn_uops | output | 3 | Micro-ops sent to rename this cycle |
| seq_start | output | 1 | Lane-0 record handed to the microcode sequencer |
| seq_busy | output | 1 | Microcode sequencer streaming |
| seq_done | output | 1 | Sequencer sends its last micro-ops this cycle |

## Verification
The assertions take three things for granted about the inputs. First, the valid bits form a prefix from lane 0. Second, every valid record carries at least one micro-op. Third, the queue pops exactly `consumed` records, so the head moves by that amount. The stimulus keeps to these rules by building every cycle's lanes from a bench-side program with a moving head pointer. It varies only the number of lanes offered, from zero to five, and draws micro-op counts from 1 to 11. The bench stresses the ordering corners. These include a multi-op record behind the head, a group that would exceed the rename cap, pairs in long mode, two pairs in one window and a sequencer hand-off behind a simple record.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_st_e;
endpackage

// File: rtl/dsa_pair_detect.sv
module dsa_pair_detect #(
  parameter int NQ = 5,
  parameter int UW = 4
) (
  input  logic [NQ-1:0]    vld,
  input  logic [NQ*UW-1:0] uops,
  input  logic [NQ-1:0]    cmp,
  input  logic [NQ-1:0]    jcc,
  input  logic [NQ-1:0]    lng,
  output logic [NQ-1:0]    fuse_ok
);
  genvar i;
  generate
    for (i = 0; i < NQ; i++) begin : g_lane
      if (i < NQ - 1) begin : g_pair
        assign fuse_ok[i] = vld[i] && vld[i+1] && cmp[i] && jcc[i+1] && !lng[i]
                            && (uops[i*UW +: UW] == UW'(1))
                            && (uops[(i+1)*UW +: UW] == UW'(1));
      end else begin : g_last
        assign fuse_ok[i] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/dsa_group_pick.sv
module dsa_group_pick #(
  parameter int NQ       = 5,
  parameter int NSLOT    = 4,
  parameter int UW       = 4,
  parameter int CPLX_MAX = 4,
  parameter int RN_CAP   = 4,
  localparam int IDX_W   = $clog2(NQ),
  localparam int CNT_W   = $clog2(NQ + 1),
  localparam int RN_W    = $clog2(RN_CAP + 1),
  localparam int TW      = UW + 2
) (
  input  logic                   busy,
  input  logic [NQ-1:0]          vld,
  input  logic [NQ*UW-1:0]       uops,
  input  logic [NQ-1:0]          fuse_ok,
  output logic [NSLOT-1:0]       slot_vld,
  output logic [NSLOT*IDX_W-1:0] slot_idx,
  output logic [NSLOT*UW-1:0]    slot_uops,
  output logic [NSLOT-1:0]       slot_fused,
  output logic [CNT_W-1:0]       consumed,
  output logic [RN_W-1:0]        tot_uops,
  output logic                   start_req
);
  logic [UW-1:0] u_arr [NQ+1];
  logic          v_arr [NQ+1];
  logic          f_arr [NQ+1];

  always_comb begin
    for (int i = 0; i <= NQ; i++) begin
      if (i < NQ) begin
        u_arr[i] = uops[i*UW +: UW];
        v_arr[i] = vld[i];
        f_arr[i] = fuse_ok[i];
      end else begin
        u_arr[i] = '0;
        v_arr[i] = 1'b0;
        f_arr[i] = 1'b0;
      end
    end
  end

  always_comb begin
    logic [IDX_W:0] p;
    logic [TW-1:0]  tot;
    logic           stop;
    logic           fz;
    p          = '0;
    tot        = '0;
    stop       = 1'b0;
    fz         = 1'b0;
    slot_vld   = '0;
    slot_idx   = '0;
    slot_uops  = '0;
    slot_fused = '0;
    start_req  = 1'b0;
    for (int s = 0; s < NSLOT; s++) begin
      if (!stop && !busy && v_arr[p]) begin
        if (f_arr[p] && !fz && ((tot + TW'(1)) <= TW'(RN_CAP))) begin
          slot_vld[s]                 = 1'b1;
          slot_idx[s*IDX_W +: IDX_W]  = p[IDX_W-1:0];
          slot_uops[s*UW +: UW]       = UW'(1);
          slot_fused[s]               = 1'b1;
          fz                          = 1'b1;
          tot                         = tot + TW'(1);
          p                           = p + (IDX_W+1)'(2);
        end else if ((s == 0) && (u_arr[p] > UW'(CPLX_MAX))) begin
          start_req = 1'b1;
          p         = (IDX_W+1)'(1);
          stop      = 1'b1;
        end else if (((s == 0) || (u_arr[p] == UW'(1)))
                     && ((tot + TW'(u_arr[p])) <= TW'(RN_CAP))) begin
          slot_vld[s]                 = 1'b1;
          slot_idx[s*IDX_W +: IDX_W]  = p[IDX_W-1:0];
          slot_uops[s*UW +: UW]       = u_arr[p];
          tot                         = tot + TW'(u_arr[p]);
          p                           = p + (IDX_W+1)'(1);
        end else begin
          stop = 1'b1;
        end
      end else begin
        stop = 1'b1;
      end
    end
    consumed = CNT_W'(p);
    tot_uops = RN_W'(tot);
  end
endmodule

// File: rtl/dsa_ucode_seq.sv
module dsa_ucode_seq
  import dsa_pkg::*;
#(
  parameter int UW     = 4,
  parameter int RN_CAP = 4,
  localparam int RN_W  = $clog2(RN_CAP + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [UW-1:0]   start_uops,
  output logic            busy,
  output logic [RN_W-1:0] emit,
  output logic            done
);
  seq_st_e       st_q, st_d;
  logic [UW-1:0] rem_q, rem_d;
  logic [UW-1:0] emit_w;
  logic          en;

  always_comb begin
    busy   = (st_q == SEQ_RUN);
    emit_w = '0;
    if (busy) emit_w = (rem_q > UW'(RN_CAP)) ? UW'(RN_CAP) : rem_q;
    emit   = RN_W'(emit_w);
    done   = busy && (rem_q <= UW'(RN_CAP));
    en     = start || busy;
    st_d   = st_q;
    rem_d  = rem_q;
    if (start) begin
      st_d  = SEQ_RUN;
      rem_d = start_uops;
    end else if (busy) begin
      rem_d = rem_q - emit_w;
      if (done) st_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      rem_q <= '0;
    end else if (en) begin
      st_q  <= st_d;
      rem_q <= rem_d;
    end
  end
endmodule

// File: rtl/dec_slot_alloc.sv
module dec_slot_alloc #(
  parameter int NQ       = 5,
  parameter int NSLOT    = 4,
  parameter int UW       = 4,
  parameter int CPLX_MAX = 4,
  parameter int RN_CAP   = 4,
  localparam int IDX_W   = $clog2(NQ),
  localparam int CNT_W   = $clog2(NQ + 1),
  localparam int RN_W    = $clog2(RN_CAP + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NQ-1:0]          iq_vld,
  input  logic [NQ*UW-1:0]       iq_uops,
  input  logic [NQ-1:0]          iq_cmp,
  input  logic [NQ-1:0]          iq_jcc,
  input  logic [NQ-1:0]          iq_long,
  output logic [NSLOT-1:0]       slot_vld,
  output logic [NSLOT*IDX_W-1:0] slot_idx,
  output logic [NSLOT*UW-1:0]    slot_uops,
  output logic [NSLOT-1:0]       slot_fused,
  output logic [CNT_W-1:0]       consumed,
  output logic [RN_W-1:0]        rn_uops,
  output logic                   seq_start,
  output logic                   seq_busy,
  output logic                   seq_done
);
  logic [NQ-1:0]   fuse_ok;
  logic [RN_W-1:0] grp_uops;
  logic [RN_W-1:0] seq_emit;
  logic            start_req;

  dsa_pair_detect #(.NQ(NQ), .UW(UW)) u_pair (
    .vld(iq_vld), .uops(iq_uops), .cmp(iq_cmp), .jcc(iq_jcc),
    .lng(iq_long), .fuse_ok(fuse_ok)
  );

  dsa_group_pick #(.NQ(NQ), .NSLOT(NSLOT), .UW(UW), .CPLX_MAX(CPLX_MAX),
                   .RN_CAP(RN_CAP)) u_pick (
    .busy(seq_busy), .vld(iq_vld), .uops(iq_uops), .fuse_ok(fuse_ok),
    .slot_vld(slot_vld), .slot_idx(slot_idx), .slot_uops(slot_uops),
    .slot_fused(slot_fused), .consumed(consumed), .tot_uops(grp_uops),
    .start_req(start_req)
  );

  dsa_ucode_seq #(.UW(UW), .RN_CAP(RN_CAP)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_req), .start_uops(iq_uops[UW-1:0]),
    .busy(seq_busy), .emit(seq_emit), .done(seq_done)
  );

  assign seq_start = start_req;
  assign rn_uops   = seq_busy ? seq_emit : grp_uops;
endmodule

// File: rtl/dsa_chk.sv
module dsa_chk #(
  parameter int NQ       = 5,
  parameter int NSLOT    = 4,
  parameter int UW       = 4,
  parameter int CPLX_MAX = 4,
  parameter int RN_CAP   = 4,
  localparam int IDX_W   = $clog2(NQ),
  localparam int CNT_W   = $clog2(NQ + 1),
  localparam int RN_W    = $clog2(RN_CAP + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NQ-1:0]          iq_long,
  input logic [NSLOT-1:0]       slot_vld,
  input logic [NSLOT*IDX_W-1:0] slot_idx,
  input logic [NSLOT*UW-1:0]    slot_uops,
  input logic [NSLOT-1:0]       slot_fused,
  input logic [CNT_W-1:0]       consumed,
  input logic [RN_W-1:0]        rn_uops,
  input logic                   seq_start,
  input logic                   seq_busy,
  input logic                   seq_done
);
  AST_CPLX_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_vld[0] |-> (slot_uops[UW-1:0] != '0) && (slot_uops[UW-1:0] <= UW'(CPLX_MAX))); // R1
  AST_RN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    rn_uops <= RN_W'(RN_CAP)); // R4
  AST_ONE_FUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(slot_fused) <= 1); // R8
  AST_SEQ_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> (consumed == '0) && (slot_vld == '0)); // R6
  AST_SEQ_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> seq_busy); // R5
  AST_SEQ_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_busy); // R6

  genvar s;
  generate
    for (s = 0; s < NSLOT; s++) begin : g_slot
      AST_NO_LONG_FUSE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_fused[s] |-> !iq_long[slot_idx[s*IDX_W +: IDX_W]]); // R9
      if (s > 0) begin : g_simple
        AST_SIMPLE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
          slot_vld[s] |-> (slot_uops[s*UW +: UW] == UW'(1))); // R2
        AST_SLOTS_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
          slot_vld[s] |-> slot_vld[s-1]); // R3
      end
    end
  endgenerate
endmodule

bind dec_slot_alloc dsa_chk #(.NQ(NQ), .NSLOT(NSLOT), .UW(UW), .CPLX_MAX(CPLX_MAX),
                              .RN_CAP(RN_CAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .iq_long(iq_long), .slot_vld(slot_vld),
  .slot_idx(slot_idx), .slot_uops(slot_uops), .slot_fused(slot_fused),
  .consumed(consumed), .rn_uops(rn_uops), .seq_start(seq_start),
  .seq_busy(seq_busy), .seq_done(seq_done)
);

// File: tb/dec_slot_alloc_tb.sv
`timescale 1ns/1ps
module dec_slot_alloc_tb;
  localparam int NQ = 5, NS = 4, UW = 4;

  logic clk, rst_n;
  logic [NQ-1:0]    iq_vld, iq_cmp, iq_jcc, iq_long;
  logic [NQ*UW-1:0] iq_uops;
  logic [NS-1:0]    slot_vld, slot_fused;
  logic [NS*3-1:0]  slot_idx;
  logic [NS*UW-1:0] slot_uops;
  logic [2:0]       consumed, rn_uops;
  logic             seq_start, seq_busy, seq_done;

  dec_slot_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .iq_vld(iq_vld), .iq_uops(iq_uops),
    .iq_cmp(iq_cmp), .iq_jcc(iq_jcc), .iq_long(iq_long),
    .slot_vld(slot_vld), .slot_idx(slot_idx), .slot_uops(slot_uops),
    .slot_fused(slot_fused), .consumed(consumed), .rn_uops(rn_uops),
    .seq_start(seq_start), .seq_busy(seq_busy), .seq_done(seq_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  int pu[4096]; bit pc[4096]; bit pj[4096]; bit pl[4096];
  int head = 0, tail = 0, avail = 5;
  int nv;
  int lu[NQ]; bit lc[NQ]; bit lj[NQ]; bit ll[NQ];
  bit rbusy = 0; int rrem = 0;
  int e_cons, e_rn; bit e_start, e_done;
  logic [NS-1:0] e_svld, e_sfus; logic [NS*3-1:0] e_sidx; logic [NS*UW-1:0] e_suops;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic drive();
    nv = 0;
    iq_vld = '0; iq_uops = '0; iq_cmp = '0; iq_jcc = '0; iq_long = '0;
    for (int i = 0; i < NQ; i++) begin
      lu[i] = 0; lc[i] = 0; lj[i] = 0; ll[i] = 0;
      if (i < avail && head + i < tail) begin
        lu[i] = pu[head+i]; lc[i] = pc[head+i]; lj[i] = pj[head+i]; ll[i] = pl[head+i];
        iq_vld[i] = 1'b1; iq_uops[i*UW +: UW] = UW'(lu[i]);
        iq_cmp[i] = lc[i]; iq_jcc[i] = lj[i]; iq_long[i] = ll[i];
        nv++;
      end
    end
  endtask

  // behavioural reference for the current cycle
  task automatic model();
    int k, s, tot; bit fu;
    e_cons = 0; e_rn = 0; e_start = 0; e_done = 0;
    e_svld = '0; e_sfus = '0; e_sidx = '0; e_suops = '0;
    if (rbusy) begin
      e_rn = (rrem > 4) ? 4 : rrem;
      e_done = (rrem <= 4);
      return;
    end
    k = 0; s = 0; tot = 0; fu = 0;
    while (s < NS && k < nv) begin
      if (!fu && k + 1 < nv && lc[k] && lj[k+1] && !ll[k] && lu[k] == 1 && lu[k+1] == 1
          && tot < 4) begin
        e_svld[s] = 1; e_sfus[s] = 1; e_sidx[s*3 +: 3] = 3'(k); e_suops[s*UW +: UW] = 1;
        fu = 1; tot++; k += 2; s++;
        continue;
      end
      if (s == 0 && lu[k] > 4) begin
        e_start = 1; k = 1;
        break;
      end
      if (s > 0 && lu[k] != 1) break;
      if (tot + lu[k] > 4) break;
      e_svld[s] = 1; e_sidx[s*3 +: 3] = 3'(k); e_suops[s*UW +: UW] = UW'(lu[k]);
      tot += lu[k]; k++; s++;
    end
    e_cons = k; e_rn = e_start ? 0 : tot;
  endtask

  // one clock: compare at negedge, advance reference after posedge
  task automatic step();
    @(negedge clk);
    model();
    chk("R3 slot_vld", slot_vld, e_svld);
    chk("R3 slot_idx", slot_idx, e_sidx);
    chk("R1 slot_uops", slot_uops, e_suops);
    chk("R7 slot_fused", slot_fused, e_sfus);
    chk("R2 consumed", consumed, e_cons);
    chk("R4 rn_uops", rn_uops, e_rn);
    chk("R5 seq_start", seq_start, e_start);
    chk("R6 seq_busy", seq_busy, rbusy);
    chk("R6 seq_done", seq_done, e_done);
    @(posedge clk); #1;
    if (e_start) begin rbusy = 1; rrem = lu[0]; end
    else if (rbusy) begin rrem -= e_rn; if (rrem == 0) rbusy = 0; end
    head += e_cons;
    drive();
  endtask

  task automatic add(input int u, input bit c, input bit j, input bit l);
    pu[tail] = u; pc[tail] = c; pj[tail] = j; pl[tail] = l; tail++;
  endtask

  task automatic run_dir(input string tag, input int exp_cyc);
    int cyc = 0;
    avail = 5; drive();
    while ((head < tail || rbusy) && cyc < 100) begin step(); cyc++; end
    chk(tag, cyc, exp_cyc);
  endtask

  initial begin
    rst_n = 1'b0; avail = 0; drive();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset slot_vld", slot_vld, 0);
    chk("R10 reset consumed", consumed, 0);
    chk("R10 reset seq_busy", seq_busy, 0);
    chk("R10 reset rn_uops", rn_uops, 0);
    @(posedge clk); #1;
    // R4: 4,1,1,1 needs two cycles under the rename cap
    add(4,0,0,0); add(1,0,0,0); add(1,0,0,0); add(1,0,0,0);
    run_dir("R4 cycles for 4,1,1,1", 2);
    // R2: 2,2,2,1 needs three cycles
    add(2,0,0,0); add(2,0,0,0); add(2,0,0,0); add(1,0,0,0);
    run_dir("R2 cycles for 2,2,2,1", 3);
    // R7: compare+jump then three singles in one cycle
    add(1,1,0,0); add(1,0,1,0); add(1,0,0,0); add(1,0,0,0); add(1,0,0,0);
    run_dir("R7 five records in one cycle", 1);
    // R9: same in long mode, no fusion
    add(1,1,0,1); add(1,0,1,1); add(1,0,0,1); add(1,0,0,1); add(1,0,0,1);
    run_dir("R9 long mode not fused", 2);
    // R8: two pairs, only one fused
    add(1,1,0,0); add(1,0,1,0); add(1,1,0,0); add(1,0,1,0);
    run_dir("R8 second pair split", 1);
    // R5/R6: 1, 9, 1 -> 1 | start | 4 | 4 | 1 | 1
    add(1,0,0,0); add(9,0,0,0); add(1,0,0,0);
    run_dir("R5 R6 sequencer hand-off", 6);
    // random traffic with partial lane availability
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom % 16;
      int u = (r < 9) ? 1 : (r < 13) ? 2 + $urandom % 3 : 5 + $urandom % 7;
      add(u, ($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 5) == 0);
    end
    drive();
    while (head < tail || rbusy) begin
      avail = ($urandom % 4 == 0) ? $urandom % 6 : 5;
      drive();
      step();
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule